// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects 32 level-sensitive interrupt requests from peripherals and steers each one to one of 15 CPU interrupt lines, or to none. Software enables sources one at a time through an enable register, reads which enabled sources are currently asserting through a pending register, and picks a destination line for every source through a 4-bit selector. Each CPU line is the OR of all enabled, asserting sources whose selector names it.

Access is through a plain 32-bit register bus with a select, a write strobe and a byte address. Read data is combinational from the address. The register window spans 0x18 bytes. Offset 0x00 holds the enable bits, offset 0x04 holds the pending bits, and offsets 0x08 to 0x14 hold the four selector words. Inputs 24 to 31 sit in the selector word at the lowest address, and inputs 0 to 7 sit in the one at the highest address. The CPU lines come from flops, so they trail the inputs by one clock.

Top module: `irq_router`

## Requirements
- R1: After reset the enable register and all four selector words read 0, and `irq_out` is 0 even when every input is high.
- R2: The enable register at offset 0x00 can be written and reads back the written value. A 0 in bit n blocks input n.
- R3: The pending register at offset 0x04 reads `irq_in & enable`. A write to it changes neither it nor any other register.
- R4: The selector for input n is the 4-bit field at bits 4*(n mod 8) of selector word 3 - floor(n/8). Selector word w is at offset 0x08 + 4*w. Each selector word reads back what was written.
- R5: Selector value 0 connects input n to no output. Selector value v in 1..15 connects it to output v-1.
- R6: Output k is high when at least one input is pending and has selector value k+1. Several such inputs on one output are ORed together.
- R7: A change on `irq_in` appears on `irq_out` exactly one clock edge later. It does not appear at an earlier edge.
- R8: Reads at offsets 0x18 and 0x1C return 0. Writes there leave every register unchanged.
- R9: When a source drops, its pending bit reads 0 at once, and its output falls at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address within the window. Bits 1:0 are ignored. |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_in | input | 32 | Level interrupt requests from peripherals |
| irq_out | output | 15 | Interrupt lines to the CPU |

## Verification
The bench places sources at the edge of each selector word (inputs 0, 8, 16, 17, 23 and 31). A design that reversed the word order or mis-shifted the field would raise the wrong output or none. It routes two inputs to one line to catch an output that follows only a single source. It also checks that selector 0 leaves the outputs quiet with every input high, so a design that treated 0 as output 0 would fire line 0. Further checks write the pending register and the unmapped offsets and then read everything back, to catch decoders that alias those addresses onto real registers. Output timing is sampled both before and after the one clock edge, which exposes a combinational path or an extra flop.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int IRQ_SRC_N   = 32;
    localparam int IRQ_DST_N   = 15;
    localparam int SEL_W       = 4;
    localparam int BUS_W       = 32;
    localparam int BUS_ADDR_W  = 5;
    localparam int SEL_PER_WD  = BUS_W / SEL_W;
    localparam int SEL_WORDS   = IRQ_SRC_N / SEL_PER_WD;
    localparam int WIDX_ENABLE = 0;
    localparam int WIDX_PEND   = 1;
    localparam int WIDX_SEL0   = 2;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int SRC_N  = IRQ_SRC_N,
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    input  logic [SRC_N-1:0]         irq_in,
    output logic [SRC_N-1:0]         enable_q,
    output logic [SEL_WORDS*BUS_W-1:0] sel_flat
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              do_wr;
    logic [BUS_W-1:0]  sel_q [SEL_WORDS];
    logic [SRC_N-1:0]  pend;

    assign widx  = bus_addr[ADDR_W-1:2];
    assign do_wr = bus_sel && bus_wr;
    assign pend  = irq_in & enable_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (do_wr && widx == WIDX_W'(WIDX_ENABLE)) begin
            enable_q <= bus_wdata[SRC_N-1:0];
        end
    end

    for (genvar w = 0; w < SEL_WORDS; w++) begin : g_selw
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[w] <= '0;
            end else if (do_wr && widx == WIDX_W'(WIDX_SEL0 + w)) begin
                sel_q[w] <= bus_wdata;
            end
        end
        assign sel_flat[w*BUS_W +: BUS_W] = sel_q[w];
    end

    always_comb begin
        bus_rdata = '0;
        if (widx == WIDX_W'(WIDX_ENABLE)) begin
            bus_rdata[SRC_N-1:0] = enable_q;
        end else if (widx == WIDX_W'(WIDX_PEND)) begin
            bus_rdata[SRC_N-1:0] = pend;
        end else begin
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (widx == WIDX_W'(WIDX_SEL0 + w)) begin
                    bus_rdata = sel_q[w];
                end
            end
        end
    end

    // R3: writes to the pending register leave all state alone
    p_pend_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && widx == WIDX_W'(WIDX_PEND)) |=> ($stable(enable_q) && $stable(sel_flat)));

    // R8: writes to unmapped offsets leave all state alone
    p_hole_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && widx >= WIDX_W'(WIDX_SEL0 + SEL_WORDS)) |=> ($stable(enable_q) && $stable(sel_flat)));

    // R3: a pending read never shows an input that is low or disabled
    p_pend_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && widx == WIDX_W'(WIDX_PEND)) |->
        (((bus_rdata[SRC_N-1:0] & ~irq_in) == '0) && ((bus_rdata[SRC_N-1:0] & ~enable_q) == '0)));

    // R1: state is clear on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (enable_q == '0 && sel_flat == '0));
endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int SRC_N = IRQ_SRC_N,
    parameter int DST_N = IRQ_DST_N
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SRC_N-1:0]           irq_in,
    input  logic [SRC_N-1:0]           enable_q,
    input  logic [SEL_WORDS*BUS_W-1:0] sel_flat,
    output logic [DST_N-1:0]           irq_out
);
    logic [SEL_W-1:0] src_sel [SRC_N];
    logic [SRC_N-1:0] active;
    logic [DST_N-1:0] out_d;

    assign active = irq_in & enable_q;

    // inverted word order: input n lives in word (SEL_WORDS-1 - n/SEL_PER_WD)
    for (genvar n = 0; n < SRC_N; n++) begin : g_src
        assign src_sel[n] = sel_flat[(SEL_WORDS - 1 - n / SEL_PER_WD) * BUS_W
                                     + SEL_W * (n % SEL_PER_WD) +: SEL_W];
    end

    for (genvar k = 0; k < DST_N; k++) begin : g_dst
        logic [SRC_N-1:0] hit;
        for (genvar n = 0; n < SRC_N; n++) begin : g_hit
            assign hit[n] = active[n] && (src_sel[n] == SEL_W'(k + 1));
        end
        assign out_d[k] = |hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= '0;
        end else begin
            irq_out <= out_d;
        end
    end

    // R6: with every input disabled the outputs go quiet next cycle
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |=> (irq_out == '0));

    // R5: with every selector at zero nothing is connected
    p_unrouted_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat == '0) |=> (irq_out == '0));

    // R7: an asserted output needs an active source one cycle earlier
    p_out_follows_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> $past(active != '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int SRC_N  = IRQ_SRC_N,
    parameter int DST_N  = IRQ_DST_N,
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [SRC_N-1:0]  irq_in,
    output logic [DST_N-1:0]  irq_out
);
    logic [SRC_N-1:0]           enable_q;
    logic [SEL_WORDS*BUS_W-1:0] sel_flat;

    irq_route_regs #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .enable_q  (enable_q),
        .sel_flat  (sel_flat)
    );

    irq_route_fabric #(.SRC_N(SRC_N), .DST_N(DST_N)) u_fabric (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .enable_q (enable_q),
        .sel_flat (sel_flat),
        .irq_out  (irq_out)
    );

    // R8: unmapped offsets read as zero
    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(WIDX_SEL0 + SEL_WORDS))
        |-> (bus_rdata == '0));
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [14:0] irq_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    // {enable, irq_in, word0 @0x08, word1 @0x0C, word2 @0x10, word3 @0x14, expected irq_out}
    localparam int VW = 32*6 + 15;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 15'h0001}, // in0 -> out0
        {32'hFFFF_FFFF, 32'h8000_0000, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 15'h4000}, // in31 -> out14
        {32'hFFFF_FFFF, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_0003, 32'h0, 15'h0004}, // in8 -> out2
        {32'hFFFF_FFFF, 32'h0000_0003, 32'h0, 32'h0, 32'h0, 32'h0000_0055, 15'h0010}, // in0,in1 -> out4
        {32'hFFFF_FFFE, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 15'h0000}, // in0 disabled
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 15'h0000},         // all unrouted
        {32'hFFFF_FFFF, 32'h0002_0000, 32'h0, 32'h0000_0020, 32'h0, 32'h0, 15'h0002}, // in17 -> out1
        {32'hFFFF_FFFF, 32'h0081_0000, 32'h0, 32'h8000_0008, 32'h0, 32'h0, 15'h0080}  // in16,in23 -> out7
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++; total++;
                $display("FAIL watchdog got=%0d exp=<20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        irq_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_out", {17'h0, irq_out}, 32'h0);
        bus_read(5'h00, rd); check("R1 enable", rd, 32'h0);
        bus_read(5'h04, rd); check("R1 pending", rd, 32'h0);
        for (int w = 0; w < 4; w++) begin
            bus_read(5'(8 + 4*w), rd); check("R1 selword", rd, 32'h0);
        end

        // R2: enable readback
        bus_write(5'h00, 32'hA5A5_5A5A);
        bus_read(5'h00, rd); check("R2 enable readback", rd, 32'hA5A5_5A5A);

        // R4: each selector word holds its own value
        for (int w = 0; w < 4; w++) bus_write(5'(8 + 4*w), 32'h1111_1111 * (w + 1));
        for (int w = 0; w < 4; w++) begin
            bus_read(5'(8 + 4*w), rd); check("R4 selword readback", rd, 32'h1111_1111 * (w + 1));
        end

        // R4 R5 R6: vector table
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            bus_write(5'h00, v[VW-1 -: 32]);
            bus_write(5'h08, v[15+127 -: 32]);
            bus_write(5'h0C, v[15+95 -: 32]);
            bus_write(5'h10, v[15+63 -: 32]);
            bus_write(5'h14, v[15+31 -: 32]);
            irq_in = v[15+159 -: 32];
            @(negedge clk);
            check("R6 vector irq_out", {17'h0, irq_out}, {17'h0, v[14:0]});
            bus_read(5'h04, rd); check("R3 vector pending", rd, v[VW-1 -: 32] & v[15+159 -: 32]);
        end

        // R7: one edge of latency; in5 -> out0 (word3 bits 23:20 = 1)
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_write(5'h08, 32'h0); bus_write(5'h0C, 32'h0); bus_write(5'h10, 32'h0);
        bus_write(5'h14, 32'h0010_0000);
        irq_in = 32'h0;
        @(negedge clk);
        check("R7 idle", {17'h0, irq_out}, 32'h0);
        irq_in = 32'h0000_0020;
        #1 check("R7 not before edge", {17'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 after one edge", {17'h0, irq_out}, 32'h1);

        // R3: pending write ignored
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, rd); check("R3 pending after write", rd, 32'h0000_0020);
        bus_read(5'h00, rd); check("R3 enable after pending write", rd, 32'hFFFF_FFFF);

        // R8: unmapped offsets
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h18, rd); check("R8 read 0x18", rd, 32'h0);
        bus_read(5'h1C, rd); check("R8 read 0x1C", rd, 32'h0);
        bus_read(5'h14, rd); check("R8 word3 kept", rd, 32'h0010_0000);
        bus_read(5'h08, rd); check("R8 word0 kept", rd, 32'h0);
        check("R8 irq_out kept", {17'h0, irq_out}, 32'h1);

        // R9: source drop
        @(negedge clk);
        irq_in = 32'h0;
        #1 check("R9 still high before edge", {17'h0, irq_out}, 32'h1);
        @(negedge clk);
        check("R9 out falls", {17'h0, irq_out}, 32'h0);
        bus_read(5'h04, rd); check("R9 pending clear", rd, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule